// File: doc/BRIEF.md
# Filtered Translation-Unit Event Counter Bank

This block holds a parameterised number of event counters for an address-translation unit. The unit sends at most one event strobe per cycle. Each strobe carries a group index, a one-hot select bit and five transaction attributes: requester ID, domain ID, PASID, ATS attribute and page-table attribute. A counter advances only when all of these hold: the strobe's group equals the counter's configured group, the strobe's select bit is set in the counter's select mask, and every filter the counter has enabled matches the strobe.

Software uses a synchronous read/write register port. Through it, software programs each counter's event word, control bits, filter values and preload value. It can start and stop counters one at a time, freeze the whole bank, and collect overflow information. Overflows go into a sticky per-counter status word and into a summary bit that drives the interrupt line. Both are write-one-to-clear. Software takes counts as deltas modulo the counter width, so each counter wraps from all-ones to zero.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter value, event word, control word and filter register reads zero. The overflow status, summary bit and freeze bit read zero, and `irq` is low.
- R2: An enabled counter adds one for each strobe whose group equals bits 31:28 of its event word (offset 0) and whose select bit is also set in bits 27:0 of that word. Any other strobe leaves the counter unchanged.
- R3: Control word (offset 1) bits 8:4 enable the filters in this order: requester ID, domain ID, PASID, ATS, page table. The filter values are held as follows: offset 3 holds the requester ID in bits 15:0 and the domain ID in bits 31:16; offset 4 holds the PASID in bits 21:0; offset 5 holds ATS in bits 4:0 and page table in bits 12:8. An enabled filter counts only on equality. A disabled filter always matches.
- R4: Control bit 0 runs the counter. A stopped counter keeps its value. A strobe in the same cycle as the write that sets the run bit is not counted.
- R5: Bit 0 of the freeze register (global offset 2) stops all counters without changing their values. Clearing it resumes counting.
- R6: A counter that increments from all-ones becomes zero and sets its own bit in the overflow status register (global offset 0).
- R7: Writing 1 to an overflow status bit clears it, and writing 0 leaves it. A wrap in the same cycle as a clear leaves the bit set.
- R8: The summary bit (global offset 1, bit 0) is set by a wrap of any counter whose control bit 1 is set. It is cleared by writing 1, and a wrap in the clearing cycle wins. `irq` equals this bit.
- R9: The register address is the counter index times 8 plus the offset, and the global registers start at NUM_CNT*8. Read data appears on the cycle after `rd_en` and has no side effect. A write to offset 2 preloads the counter and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| ev_valid | input | 1 | Event strobe |
| ev_grp | input | 4 | Event group index |
| ev_sel | input | 28 | One-hot event select |
| ev_rid | input | 16 | Requester ID of the transaction |
| ev_dom | input | 16 | Domain ID of the transaction |
| ev_pasid | input | 22 | PASID of the transaction |
| ev_ats | input | 5 | ATS attribute of the transaction |
| ev_pt | input | 5 | Page-table attribute of the transaction |
| irq | output | 1 | Overflow interrupt, equal to the summary bit |

## Verification
The assertions assume that every valid strobe carries exactly one select bit. One of them checks this input rule directly. The bench stimulus only ever drives one-hot selects, taken from the low four bits. The bench also draws its group, attribute and filter values from very small sets, so that matches and mismatches both occur often under random stimulus. It never drives an address outside the defined map.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 28;
  localparam int GRP_W   = 4;
  localparam int RID_W   = 16;
  localparam int DOM_W   = 16;
  localparam int PASID_W = 22;
  localparam int ATTR_W  = 5;
  localparam int NFILT   = 5;
  localparam int SLOT_W  = 3;

  // per-counter register slots
  localparam logic [SLOT_W-1:0] SLOT_EVCFG = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_CTRL  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_COUNT = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_IDF   = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_PASID = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_ATTR  = 3'd5;

  // global register slots
  localparam logic [SLOT_W-1:0] GSLOT_OVF  = 3'd0;
  localparam logic [SLOT_W-1:0] GSLOT_SUM  = 3'd1;
  localparam logic [SLOT_W-1:0] GSLOT_FRZ  = 3'd2;

  // control word fields
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_IE      = 1;
  localparam int CTRL_FEN_LSB = 4;

  // filter enable order
  localparam int FLT_RID   = 0;
  localparam int FLT_DOM   = 1;
  localparam int FLT_PASID = 2;
  localparam int FLT_ATS   = 3;
  localparam int FLT_PT    = 4;

  typedef struct packed {
    logic [RID_W-1:0]   rid;
    logic [DOM_W-1:0]   dom;
    logic [PASID_W-1:0] pasid;
    logic [ATTR_W-1:0]  ats;
    logic [ATTR_W-1:0]  pt;
  } txn_attr_t;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/pmc_filter_match.sv
module pmc_filter_match
  import pmc_pkg::*;
(
  input  logic [GRP_W-1:0] cfg_grp,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [NFILT-1:0] fen,
  input  txn_attr_t        flt,
  input  logic [GRP_W-1:0] ev_grp,
  input  logic [SEL_W-1:0] ev_sel,
  input  txn_attr_t        ev_attr,
  output logic             hit
);
  logic [NFILT-1:0] eq;

  always_comb begin
    eq            = '0;
    eq[FLT_RID]   = (flt.rid   == ev_attr.rid);
    eq[FLT_DOM]   = (flt.dom   == ev_attr.dom);
    eq[FLT_PASID] = (flt.pasid == ev_attr.pasid);
    eq[FLT_ATS]   = (flt.ats   == ev_attr.ats);
    eq[FLT_PT]    = (flt.pt    == ev_attr.pt);
  end

  // a disabled filter passes; every enabled one must compare equal
  assign hit = (cfg_grp == ev_grp) && (|(cfg_sel & ev_sel)) && (&(eq | ~fen));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_valid,
  input  logic [GRP_W-1:0]  ev_grp,
  input  logic [SEL_W-1:0]  ev_sel,
  input  txn_attr_t         ev_attr,
  input  logic              freeze,
  output logic [DATA_W-1:0] rd_word,
  output logic              wrap,
  output logic              irq_en
);
  logic [DATA_W-1:0] evcfg_q, evcfg_d;
  logic              run_q, run_d;
  logic              ie_q, ie_d;
  logic [NFILT-1:0]  fen_q, fen_d;
  txn_attr_t         flt_q, flt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_cnt;
  logic              hit;
  logic              inc;

  pmc_filter_match u_match (
    .cfg_grp (evcfg_q[SEL_W +: GRP_W]),
    .cfg_sel (evcfg_q[SEL_W-1:0]),
    .fen     (fen_q),
    .flt     (flt_q),
    .ev_grp  (ev_grp),
    .ev_sel  (ev_sel),
    .ev_attr (ev_attr),
    .hit     (hit)
  );

  // the run bit is taken from the register, so a strobe in the enabling
  // write's own cycle still sees the counter stopped
  assign inc = ev_valid && run_q && !freeze && hit;

  always_comb begin
    evcfg_d = evcfg_q;
    run_d   = run_q;
    ie_d    = ie_q;
    fen_d   = fen_q;
    flt_d   = flt_q;
    wr_cnt  = 1'b0;
    if (wr_en) begin
      case (slot)
        SLOT_EVCFG: evcfg_d = wdata;
        SLOT_CTRL: begin
          run_d = wdata[CTRL_RUN];
          ie_d  = wdata[CTRL_IE];
          fen_d = wdata[CTRL_FEN_LSB +: NFILT];
        end
        SLOT_COUNT: wr_cnt = 1'b1;
        SLOT_IDF: begin
          flt_d.rid = wdata[RID_W-1:0];
          flt_d.dom = wdata[16 +: DOM_W];
        end
        SLOT_PASID: flt_d.pasid = wdata[PASID_W-1:0];
        SLOT_ATTR: begin
          flt_d.ats = wdata[ATTR_W-1:0];
          flt_d.pt  = wdata[8 +: ATTR_W];
        end
        default: ;
      endcase
    end
  end

  // a preload overrides an increment in the same cycle
  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)   cnt_d = wdata[CNT_W-1:0];
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  assign wrap   = inc && !wr_cnt && (&cnt_q);
  assign irq_en = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evcfg_q <= '0;
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      fen_q   <= '0;
      flt_q   <= '0;
      cnt_q   <= '0;
    end else begin
      evcfg_q <= evcfg_d;
      run_q   <= run_d;
      ie_q    <= ie_d;
      fen_q   <= fen_d;
      flt_q   <= flt_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (slot)
      SLOT_EVCFG: rd_word = evcfg_q;
      SLOT_CTRL:  rd_word = {23'b0, fen_q, 2'b00, ie_q, run_q};
      SLOT_COUNT: rd_word = DATA_W'(cnt_q);
      SLOT_IDF:   rd_word = {flt_q.dom, flt_q.rid};
      SLOT_PASID: rd_word = {10'b0, flt_q.pasid};
      SLOT_ATTR:  rd_word = {19'b0, flt_q.pt, 3'b000, flt_q.ats};
      default:    rd_word = '0;
    endcase
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_cnt && (&cnt_q)) |=> (cnt_q == '0))
    else $error("counter did not wrap to zero"); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_q))
    else $error("stopped counter changed"); // R4
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_cnt) |=> $stable(cnt_q))
    else $error("frozen counter changed"); // R5
  AST_STEP_OF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !(&cnt_q)) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))))
    else $error("counter moved by more than one"); // R2
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = $clog2(NUM_CNT) + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ev_valid,
  input  logic [3:0]        ev_grp,
  input  logic [27:0]       ev_sel,
  input  logic [15:0]       ev_rid,
  input  logic [15:0]       ev_dom,
  input  logic [21:0]       ev_pasid,
  input  logic [4:0]        ev_ats,
  input  logic [4:0]        ev_pt,
  output logic              irq
);
  localparam int WIN_W = ADDR_W - SLOT_W;

  logic                rst_sn;
  logic [WIN_W-1:0]    win;
  logic [SLOT_W-1:0]   slot;
  logic                glob_sel;
  logic                glob_wr;
  txn_attr_t           ev_attr;
  logic [NUM_CNT-1:0]  wrap_v;
  logic [NUM_CNT-1:0]  ie_v;
  logic [DATA_W-1:0]   rdw [NUM_CNT];
  logic [NUM_CNT-1:0]  ovf_q, ovf_d, ovf_clr;
  logic                sum_q, sum_d, sum_clr;
  logic                frz_q, frz_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;

  pmc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  assign win      = addr[ADDR_W-1:SLOT_W];
  assign slot     = addr[SLOT_W-1:0];
  assign glob_sel = (win == WIN_W'(NUM_CNT));
  assign glob_wr  = wr_en && glob_sel;

  assign ev_attr.rid   = ev_rid;
  assign ev_attr.dom   = ev_dom;
  assign ev_attr.pasid = ev_pasid;
  assign ev_attr.ats   = ev_ats;
  assign ev_attr.pt    = ev_pt;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sn),
      .wr_en    (wr_en && (win == WIN_W'(i))),
      .slot     (slot),
      .wdata    (wdata),
      .ev_valid (ev_valid),
      .ev_grp   (ev_grp),
      .ev_sel   (ev_sel),
      .ev_attr  (ev_attr),
      .freeze   (frz_q),
      .rd_word  (rdw[i]),
      .wrap     (wrap_v[i]),
      .irq_en   (ie_v[i])
    );
  end

  // status next-state: a set in the same cycle beats a clear
  always_comb begin
    ovf_clr = (glob_wr && slot == GSLOT_OVF) ? wdata[NUM_CNT-1:0] : '0;
    sum_clr = glob_wr && (slot == GSLOT_SUM) && wdata[0];
    ovf_d   = (ovf_q & ~ovf_clr) | wrap_v;
    sum_d   = (sum_q && !sum_clr) || (|(wrap_v & ie_v));
    frz_d   = (glob_wr && slot == GSLOT_FRZ) ? wdata[0] : frz_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = '0;
      if (glob_sel) begin
        case (slot)
          GSLOT_OVF: rdata_d = DATA_W'(ovf_q);
          GSLOT_SUM: rdata_d = {31'b0, sum_q};
          GSLOT_FRZ: rdata_d = {31'b0, frz_q};
          default:   rdata_d = '0;
        endcase
      end else begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (win == WIN_W'(i)) rdata_d = rdw[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ovf_q   <= '0;
      sum_q   <= 1'b0;
      frz_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ovf_q   <= ovf_d;
      sum_q   <= sum_d;
      frz_q   <= frz_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign irq   = sum_q;

  AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_sn)
    ev_valid |-> ($countones(ev_sel) == 1))
    else $error("event select is not one-hot"); // R2
  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_sn)
    (|(wrap_v & ie_v)) |=> irq)
    else $error("enabled wrap did not raise irq"); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq && !(glob_wr && slot == GSLOT_SUM && wdata[0])) |=> irq)
    else $error("irq dropped without a clear"); // R8

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_sn)
      wrap_v[i] |=> ovf_q[i])
      else $error("wrap did not set overflow bit"); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
      (ovf_q[i] && !(glob_wr && slot == GSLOT_OVF && wdata[i])) |=> ovf_q[i])
      else $error("overflow bit dropped without a clear"); // R7
  end
endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;
  localparam int NUM = 4;
  localparam int AW  = 6;
  localparam int G   = NUM * 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic        ev_valid;
  logic [3:0]  ev_grp;
  logic [27:0] ev_sel;
  logic [15:0] ev_rid, ev_dom;
  logic [21:0] ev_pasid;
  logic [4:0]  ev_ats, ev_pt;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pmc_bank #(.NUM_CNT(NUM), .CNT_W(32)) i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_valid(ev_valid), .ev_grp(ev_grp),
    .ev_sel(ev_sel), .ev_rid(ev_rid), .ev_dom(ev_dom), .ev_pasid(ev_pasid),
    .ev_ats(ev_ats), .ev_pt(ev_pt), .irq(irq)
  );

  always #4 clk = ~clk;

  // bench model of the random-phase configuration
  logic [3:0]  m_grp [NUM];
  logic [27:0] m_sel [NUM];
  logic [4:0]  m_fen [NUM];
  logic [15:0] m_rid [NUM];
  logic [15:0] m_dom [NUM];
  logic [21:0] m_pas [NUM];
  logic [4:0]  m_ats [NUM];
  logic [4:0]  m_pt  [NUM];
  logic [31:0] m_cnt [NUM];

  function automatic int ca(int i, int s);
    return i * 8 + s;
  endfunction

  function automatic bit model_hit(int i, logic [3:0] g, logic [27:0] s, logic [15:0] r,
                                   logic [15:0] d, logic [21:0] p, logic [4:0] a, logic [4:0] t);
    bit ok;
    ok = (m_grp[i] == g) && ((m_sel[i] & s) != 0);
    if (m_fen[i][0] && m_rid[i] != r) ok = 0;
    if (m_fen[i][1] && m_dom[i] != d) ok = 0;
    if (m_fen[i][2] && m_pas[i] != p) ok = 0;
    if (m_fen[i][3] && m_ats[i] != a) ok = 0;
    if (m_fen[i][4] && m_pt[i]  != t) ok = 0;
    return ok;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; ev_valid = 0; ev_grp = '0;
    ev_sel = '0; ev_rid = '0; ev_dom = '0; ev_pasid = '0; ev_ats = '0; ev_pt = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic ev(input logic [3:0] g, input logic [27:0] s, input logic [15:0] r,
                    input logic [15:0] dm, input logic [21:0] p, input logic [4:0] a,
                    input logic [4:0] t);
    @(negedge clk);
    ev_valid = 1; ev_grp = g; ev_sel = s; ev_rid = r; ev_dom = dm;
    ev_pasid = p; ev_ats = a; ev_pt = t;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic sb(input logic [3:0] g, input logic [27:0] s);
    ev(g, s, '0, '0, '0, '0, '0);
  endtask

  // register write and event strobe in the same clock cycle
  task automatic wr_sb(input int a, input logic [31:0] d, input logic [3:0] g,
                       input logic [27:0] s);
    @(negedge clk);
    wr_en = 1; addr = AW'(a); wdata = d;
    ev_valid = 1; ev_grp = g; ev_sel = s; ev_rid = '0; ev_dom = '0;
    ev_pasid = '0; ev_ats = '0; ev_pt = '0;
    @(negedge clk);
    wr_en = 0; ev_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NUM; i++) begin
      rd(ca(i, 2), v); chk("R1 counter", v, 0);
      rd(ca(i, 1), v); chk("R1 control", v, 0);
      rd(ca(i, 0), v); chk("R1 event word", v, 0);
      rd(ca(i, 3), v); chk("R1 id filter", v, 0);
    end
    rd(G + 0, v); chk("R1 overflow", v, 0);
    rd(G + 1, v); chk("R1 summary", v, 0);
    rd(G + 2, v); chk("R1 freeze", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 group and select matching
    wr(ca(0, 0), {4'd0, 28'h3});
    wr(ca(0, 1), 32'h1);
    rd(ca(0, 0), v); chk("R9 event word readback", v, 32'h0000_0003);
    sb(4'd0, 28'h2);
    sb(4'd1, 28'h2);
    sb(4'd0, 28'h4);
    rd(ca(0, 2), v); chk("R2 group/select match", v, 1);

    // R3 filters
    wr(ca(1, 0), {4'd2, 28'h3});
    wr(ca(1, 3), {16'h7777, 16'h1234});
    wr(ca(1, 4), 32'h0002_ABCD);
    wr(ca(1, 1), 32'h1 | (32'h1 << 4) | (32'h1 << 6));
    rd(ca(1, 1), v); chk("R3 control readback", v, 32'h51);
    ev(4'd2, 28'h1, 16'h1234, 16'h0, 22'h2ABCD, 5'd0, 5'd0);
    ev(4'd2, 28'h1, 16'h1235, 16'h0, 22'h2ABCD, 5'd0, 5'd0);
    ev(4'd2, 28'h2, 16'h1234, 16'h0, 22'h2ABCC, 5'd0, 5'd0);
    ev(4'd2, 28'h2, 16'h1234, 16'h9999, 22'h2ABCD, 5'd3, 5'd4);
    rd(ca(1, 2), v); chk("R3 filter match", v, 2);
    wr(ca(1, 5), {19'b0, 5'd9, 3'b0, 5'd6});
    rd(ca(1, 5), v); chk("R3 attribute filter readback", v, 32'h0000_0906);

    // R4 per-counter run bit
    wr(ca(2, 0), {4'd3, 28'h4});
    sb(4'd3, 28'h4);
    rd(ca(2, 2), v); chk("R4 stopped counter", v, 0);
    wr_sb(ca(2, 1), 32'h1, 4'd3, 28'h4);
    rd(ca(2, 2), v); chk("R4 strobe with enable write", v, 0);
    sb(4'd3, 28'h4);
    wr(ca(2, 1), 32'h0);
    sb(4'd3, 28'h4);
    rd(ca(2, 2), v); chk("R4 counts then holds", v, 1);

    // R5 global freeze
    wr(G + 2, 32'h1);
    rd(G + 2, v); chk("R5 freeze readback", v, 1);
    sb(4'd0, 28'h1);
    rd(ca(0, 2), v); chk("R5 frozen hold", v, 1);
    wr(G + 2, 32'h0);
    sb(4'd0, 28'h1);
    rd(ca(0, 2), v); chk("R5 resumes", v, 2);

    // R6 / R8 wrap with interrupt enabled
    wr(ca(3, 0), {4'd0, 28'h2});
    wr(ca(3, 1), 32'h3);
    wr(ca(3, 2), 32'hFFFF_FFFF);
    chk("R8 irq low before wrap", {31'b0, irq}, 0);
    sb(4'd0, 28'h2);
    chk("R8 irq after wrap", {31'b0, irq}, 1);
    rd(ca(3, 2), v); chk("R6 wrap to zero", v, 0);
    rd(G + 0, v); chk("R6 overflow bit", v, 32'h8);
    rd(G + 1, v); chk("R8 summary", v, 1);

    // R7 / R8 clears
    wr(G + 0, 32'h0);
    rd(G + 0, v); chk("R7 write zero keeps", v, 32'h8);
    wr(G + 0, 32'h8);
    rd(G + 0, v); chk("R7 clear", v, 0);
    wr(G + 1, 32'h1);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // R7 set wins over clear
    wr(ca(3, 2), 32'hFFFF_FFFF);
    sb(4'd0, 28'h2);
    wr(ca(3, 2), 32'hFFFF_FFFF);
    wr_sb(G + 0, 32'h8, 4'd0, 28'h2);
    rd(G + 0, v); chk("R7 wrap beats clear", v, 32'h8);
    // R8 set wins over clear
    wr(ca(3, 2), 32'hFFFF_FFFF);
    wr_sb(G + 1, 32'h1, 4'd0, 28'h2);
    chk("R8 wrap beats clear", {31'b0, irq}, 1);
    wr(G + 1, 32'h1);
    wr(G + 0, 32'hF);
    // R8 wrap without interrupt enable
    wr(ca(0, 2), 32'hFFFF_FFFF);
    sb(4'd0, 28'h1);
    rd(G + 0, v); chk("R6 overflow without ie", v, 32'h1);
    chk("R8 no irq without ie", {31'b0, irq}, 0);

    // R9 preload priority and side-effect-free reads
    wr(ca(0, 2), 32'h0000_0010);
    wr_sb(ca(0, 2), 32'h0000_0100, 4'd0, 28'h1);
    rd(ca(0, 2), v); rd(ca(0, 2), v2);
    chk("R9 preload beats increment", v, 32'h100);
    chk("R9 read has no side effect", v2, v);

    // random phase (R2, R3, R5)
    for (int i = 0; i < NUM; i++) begin
      m_grp[i] = 4'($urandom_range(0, 3));
      m_sel[i] = 28'($urandom_range(1, 15));
      m_fen[i] = 5'($urandom_range(0, 31));
      m_rid[i] = 16'($urandom_range(0, 1));
      m_dom[i] = 16'($urandom_range(0, 1));
      m_pas[i] = 22'($urandom_range(0, 1));
      m_ats[i] = 5'($urandom_range(0, 1));
      m_pt[i]  = 5'($urandom_range(0, 1));
      m_cnt[i] = 0;
      wr(ca(i, 0), {m_grp[i], m_sel[i]});
      wr(ca(i, 3), {m_dom[i], m_rid[i]});
      wr(ca(i, 4), {10'b0, m_pas[i]});
      wr(ca(i, 5), {19'b0, m_pt[i], 3'b0, m_ats[i]});
      wr(ca(i, 2), 32'h0);
      wr(ca(i, 1), {23'b0, m_fen[i], 2'b00, 1'b0, 1'b1});
    end
    begin
      bit frz = 0;
      for (int k = 0; k < 400; k++) begin
        if ($urandom_range(0, 15) == 0) begin
          frz = !frz;
          wr(G + 2, {31'b0, frz});
        end else begin
          logic [3:0]  g;
          logic [27:0] s;
          logic [15:0] r, dm;
          logic [21:0] p;
          logic [4:0]  a, t;
          g  = 4'($urandom_range(0, 3));
          s  = 28'h1 << $urandom_range(0, 3);
          r  = 16'($urandom_range(0, 1));
          dm = 16'($urandom_range(0, 1));
          p  = 22'($urandom_range(0, 1));
          a  = 5'($urandom_range(0, 1));
          t  = 5'($urandom_range(0, 1));
          ev(g, s, r, dm, p, a, t);
          for (int i = 0; i < NUM; i++)
            if (!frz && model_hit(i, g, s, r, dm, p, a, t)) m_cnt[i] = m_cnt[i] + 1;
        end
      end
      wr(G + 2, 32'h0);
    end
    for (int i = 0; i < NUM; i++) begin
      rd(ca(i, 2), v);
      chk($sformatf("R2 R3 R5 random counter %0d", i), v, m_cnt[i]);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule